// File: doc/BRIEF.md
# Single-Sideband Up-Converter with Numerically Controlled Oscillator

This block mixes a complex baseband sample pair with a digitally generated carrier. A 32-bit phase accumulator advances by a programmable tuning word each clock. The ten most significant bits of the accumulator are added to a 16-bit phase offset, aligned at the top bit, to form an address into a quarter-wave sine table. The table returns a sine and a cosine value, both 14-bit signed. A complex multiplier then produces two output channels, one real and one quadrature, that carry the upper or the lower sideband with either sign convention. Results are rounded to nearest and clipped to 14 bits.

A three-bit selector picks plain two-channel pass-through or one of four sideband modes. Code 000 passes the samples through unchanged, and codes 101 to 111 do the same. When the oscillator enable is low, the accumulator is forced to zero and held there. A low-power switch keeps only the five top bits of the tuning word and of the phase offset. Every output is registered. A sample presented on a clock edge appears at the outputs two edges later. The reset input is asynchronous and active-low, and it is released through a two-stage synchronizer.

Top module: `nco_ssb_mod`

## Requirements
- R1: While reset is asserted, out_a and out_b are zero.
- R2: An input sample reaches out_a/out_b exactly two rising clock edges after it is applied. The phase that mixes with it is the accumulator value before the first of those edges, plus the offset.
- R3: While nco_en is 1, the accumulator grows by freq_word (mod 2^32) on every edge. A tuning word of 0x40000000 steps the carrier a quarter turn per clock, and a phase_ofs of 0x4000 is +90 degrees.
- R4: An edge with nco_en at 0 loads zero into the accumulator and keeps it there. phase_ofs still applies while the accumulator is held.
- R5: mod_sel values 000, 101, 110 and 111 give out_a = in_i and out_b = in_q.
- R6: mod_sel 001 gives out_a = I·cos − Q·sin and out_b = Q·cos + I·sin.
- R7: mod_sel 010 gives out_a = I·cos + Q·sin and out_b = Q·cos − I·sin.
- R8: mod_sel 011 gives out_a = I·cos − Q·sin and out_b = Q·cos − I·sin.
- R9: mod_sel 100 gives out_a = I·cos + Q·sin and out_b = Q·cos + I·sin.
- R10: With lp_mode at 1, only bits 31:27 of freq_word and bits 15:11 of phase_ofs take effect. The low accumulator bits then stay zero once they are zero.
- R11: Each modulated sum of 14x14 products is divided by 2^13 with round-half-up. This is done as floor((sum + 4096) / 8192).
- R12: Modulated results above 8191 become 8191, and results below −8192 become −8192.
- R13: At whole quarter-turn phases, sine and cosine are exactly 0 or ±8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nco_en | input | 1 | Oscillator enable; 0 clears and holds the accumulator |
| lp_mode | input | 1 | Low-power, five-bit tuning and offset |
| mod_sel | input | 3 | Pass-through or sideband mode code |
| freq_word | input | 32 | Phase increment per clock |
| phase_ofs | input | 16 | Phase offset, full turn = 2^16 |
| in_i | input | 14 | In-phase sample, two's complement |
| in_q | input | 14 | Quadrature sample, two's complement |
| out_a | output | 14 | Real output channel |
| out_b | output | 14 | Quadrature output channel |

## Verification
The accumulator clear and the accumulator step can fall in the same cycle. The bench lowers nco_en while a quarter-turn rotation is running. It then expects the outputs to settle on the zero-phase result within three edges, with no sign of a final step. Low-power masking and the phase offset also act in the same address computation. A 0x47FF offset is applied with lp_mode set, which must give exactly the +90 degree result. The same offset is applied with lp_mode clear, which must give a different result. A long rotation run in low-power mode with a dirty tuning word must keep the exact quarter-step pattern.

// File: rtl/nco_ssb_pkg.sv
package nco_ssb_pkg;

  localparam int MODE_W = 3;

  // Mixer control derived from the mode code
  typedef struct packed {
    logic active;   // 0: pass samples through
    logic a_plus;   // 1: channel a adds the sine term
    logic b_minus;  // 1: channel b subtracts the sine term
  } mix_ctl_t;

  function automatic mix_ctl_t decode_mode(logic [MODE_W-1:0] code);
    mix_ctl_t c;
    c = '0;
    case (code)
      3'b001: c = '{active: 1'b1, a_plus: 1'b0, b_minus: 1'b0};
      3'b010: c = '{active: 1'b1, a_plus: 1'b1, b_minus: 1'b1};
      3'b011: c = '{active: 1'b1, a_plus: 1'b0, b_minus: 1'b1};
      3'b100: c = '{active: 1'b1, a_plus: 1'b1, b_minus: 1'b0};
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/nco_phase_gen.sv
module nco_phase_gen #(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  parameter int ADDR_W  = 10,
  parameter int LP_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nco_en,
  input  logic              lp_mode,
  input  logic [FREQ_W-1:0] freq_word,
  input  logic [PHASE_W-1:0] phase_ofs,
  output logic [ADDR_W-1:0] lut_addr
);

  localparam logic [FREQ_W-1:0]  FREQ_KEEP  = {{LP_BITS{1'b1}}, {(FREQ_W-LP_BITS){1'b0}}};
  localparam logic [PHASE_W-1:0] PHASE_KEEP = {{LP_BITS{1'b1}}, {(PHASE_W-LP_BITS){1'b0}}};

  logic [FREQ_W-1:0]  fw_eff;
  logic [PHASE_W-1:0] ofs_eff;
  logic [FREQ_W-1:0]  acc_q, acc_d;
  logic               acc_ce;

  always_comb begin
    fw_eff   = lp_mode ? (freq_word & FREQ_KEEP) : freq_word;
    ofs_eff  = lp_mode ? (phase_ofs & PHASE_KEEP) : phase_ofs;
    acc_ce   = nco_en | (|acc_q);
    acc_d    = nco_en ? (acc_q + fw_eff) : '0;
    lut_addr = acc_q[FREQ_W-1 -: ADDR_W] + ofs_eff[PHASE_W-1 -: ADDR_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_ce) begin
      acc_q <= acc_d;
    end
  end

  // R4
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nco_en |=> acc_q == '0);

  // R10
  lp_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode && acc_q[FREQ_W-LP_BITS-1:0] == '0) |=> acc_q[FREQ_W-LP_BITS-1:0] == '0);

endmodule

// File: rtl/nco_sincos_rom.sv
module nco_sincos_rom #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [DATA_W-1:0] sin_q,
  output logic signed [DATA_W-1:0] cos_q
);

  localparam int QW   = ADDR_W - 2;
  localparam int QN   = 1 << QW;
  localparam int HALF = 1 << (ADDR_W - 1);
  localparam int AMP  = (1 << (DATA_W - 1)) - 1;

  typedef logic [DATA_W-2:0] mag_t;
  typedef mag_t qtab_t [QN+1];

  // Rational sine approximation, exact at 0 and 90 degrees
  function automatic qtab_t build_qtab();
    qtab_t  t;
    longint p, den, num;
    for (int k = 0; k <= QN; k++) begin
      p   = longint'(k) * longint'(HALF - k);
      den = 5 * longint'(HALF) * longint'(HALF) - 4 * p;
      num = 16 * longint'(AMP) * p + den / 2;
      t[k] = mag_t'(num / den);
    end
    return t;
  endfunction

  localparam qtab_t QTAB = build_qtab();

  function automatic logic signed [DATA_W-1:0] wave(logic [ADDR_W-1:0] a);
    logic [QW:0] idx;
    mag_t        m;
    idx = a[ADDR_W-2] ? ((QW+1)'(QN) - {1'b0, a[QW-1:0]}) : {1'b0, a[QW-1:0]};
    m   = QTAB[idx];
    return a[ADDR_W-1] ? -$signed({1'b0, m}) : $signed({1'b0, m});
  endfunction

  logic [ADDR_W-1:0]        cos_addr;
  logic signed [DATA_W-1:0] sin_d, cos_d;

  always_comb begin
    cos_addr = addr + ADDR_W'(QN);
    sin_d    = wave(addr);
    cos_d    = wave(cos_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_q <= '0;
      cos_q <= '0;
    end else begin
      sin_q <= sin_d;
      cos_q <= cos_d;
    end
  end

  // R13
  quarter_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr[QW-1:0] == '0 |=> (sin_q == '0 || cos_q == '0));

  // R13
  quarter_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr[QW-1:0] == '0 |=> (sin_q == AMP || sin_q == -AMP || cos_q == AMP || cos_q == -AMP));

endmodule

// File: rtl/nco_ssb_mixer.sv
module nco_ssb_mixer
  import nco_ssb_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [MODE_W-1:0]        mod_sel,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  input  logic signed [DATA_W-1:0] sin_v,
  input  logic signed [DATA_W-1:0] cos_v,
  output logic signed [DATA_W-1:0] out_a,
  output logic signed [DATA_W-1:0] out_b
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int FRAC   = DATA_W - 1;
  localparam int RES_W  = SUM_W - FRAC;
  localparam logic signed [SUM_W-1:0] HALF_LSB = SUM_W'(1) << (FRAC - 1);
  localparam logic signed [RES_W-1:0] MAXV     = RES_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [RES_W-1:0] MINV     = -MAXV - RES_W'(1);

  function automatic logic signed [DATA_W-1:0] clip(logic signed [RES_W-1:0] v);
    if (v > MAXV)      return MAXV[DATA_W-1:0];
    else if (v < MINV) return MINV[DATA_W-1:0];
    else               return v[DATA_W-1:0];
  endfunction

  mix_ctl_t                 ctl_d, ctl_q;
  logic signed [DATA_W-1:0] i_q, q_q;
  logic signed [PROD_W-1:0] p_ic, p_qs, p_qc, p_is;
  logic signed [SUM_W-1:0]  x_ic, x_qs, x_qc, x_is;
  logic signed [SUM_W-1:0]  sum_a, sum_b, rnd_a, rnd_b;
  logic signed [RES_W-1:0]  sh_a, sh_b;
  logic signed [DATA_W-1:0] out_a_d, out_b_d;

  always_comb begin
    ctl_d   = decode_mode(mod_sel);
    p_ic    = i_q * cos_v;
    p_qs    = q_q * sin_v;
    p_qc    = q_q * cos_v;
    p_is    = i_q * sin_v;
    x_ic    = {p_ic[PROD_W-1], p_ic};
    x_qs    = {p_qs[PROD_W-1], p_qs};
    x_qc    = {p_qc[PROD_W-1], p_qc};
    x_is    = {p_is[PROD_W-1], p_is};
    sum_a   = ctl_q.a_plus  ? (x_ic + x_qs) : (x_ic - x_qs);
    sum_b   = ctl_q.b_minus ? (x_qc - x_is) : (x_qc + x_is);
    rnd_a   = sum_a + HALF_LSB;
    rnd_b   = sum_b + HALF_LSB;
    sh_a    = RES_W'(rnd_a >>> FRAC);
    sh_b    = RES_W'(rnd_b >>> FRAC);
    out_a_d = ctl_q.active ? clip(sh_a) : i_q;
    out_b_d = ctl_q.active ? clip(sh_b) : q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      i_q   <= '0;
      q_q   <= '0;
      out_a <= '0;
      out_b <= '0;
    end else begin
      ctl_q <= ctl_d;
      i_q   <= in_i;
      q_q   <= in_q;
      out_a <= out_a_d;
      out_b <= out_b_d;
    end
  end

  // R5
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_d.active |=> ##1 (out_a == $past(in_i, 2) && out_b == $past(in_q, 2)));

endmodule

// File: rtl/nco_ssb_mod.sv
module nco_ssb_mod
  import nco_ssb_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 14,
  parameter int LP_BITS = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     nco_en,
  input  logic                     lp_mode,
  input  logic [MODE_W-1:0]        mod_sel,
  input  logic [FREQ_W-1:0]        freq_word,
  input  logic [PHASE_W-1:0]       phase_ofs,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  output logic signed [DATA_W-1:0] out_a,
  output logic signed [DATA_W-1:0] out_b
);

  logic [1:0]               rst_pipe;
  logic                     rst_core_n;
  logic [ADDR_W-1:0]        lut_addr;
  logic signed [DATA_W-1:0] sin_v, cos_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_core_n = rst_pipe[1];

  nco_phase_gen #(
    .FREQ_W (FREQ_W),
    .PHASE_W(PHASE_W),
    .ADDR_W (ADDR_W),
    .LP_BITS(LP_BITS)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .nco_en   (nco_en),
    .lp_mode  (lp_mode),
    .freq_word(freq_word),
    .phase_ofs(phase_ofs),
    .lut_addr (lut_addr)
  );

  nco_sincos_rom #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_rom (
    .clk  (clk),
    .rst_n(rst_core_n),
    .addr (lut_addr),
    .sin_q(sin_v),
    .cos_q(cos_v)
  );

  nco_ssb_mixer #(
    .DATA_W(DATA_W)
  ) u_mix (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .mod_sel(mod_sel),
    .in_i   (in_i),
    .in_q   (in_q),
    .sin_v  (sin_v),
    .cos_v  (cos_v),
    .out_a  (out_a),
    .out_b  (out_b)
  );

endmodule

// File: tb/nco_ssb_mod_tb.sv
module nco_ssb_mod_tb;

  logic               clk;
  logic               rst_n;
  logic               nco_en;
  logic               lp_mode;
  logic [2:0]         mod_sel;
  logic [31:0]        freq_word;
  logic [15:0]        phase_ofs;
  logic signed [13:0] in_i, in_q;
  logic signed [13:0] out_a, out_b;

  int total;
  int fails;

  nco_ssb_mod u_dut (
    .clk(clk), .rst_n(rst_n), .nco_en(nco_en), .lp_mode(lp_mode),
    .mod_sel(mod_sel), .freq_word(freq_word), .phase_ofs(phase_ofs),
    .in_i(in_i), .in_q(in_q), .out_a(out_a), .out_b(out_b)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [2:0]         mode;
    logic [15:0]        ofs;
    logic signed [13:0] vi;
    logic signed [13:0] vq;
    logic signed [13:0] ea;
    logic signed [13:0] eb;
  } vec_t;

  // Fixed phases: 0x0000 0deg, 0x4000 90deg, 0x8000 180deg, 0xC000 270deg
  localparam vec_t VEC [13] = '{
    '{3'd1, 16'h0000, 14'sd1000, -14'sd600,  14'sd1000, -14'sd600},
    '{3'd1, 16'h4000, 14'sd1000, -14'sd600,  14'sd600,   14'sd1000},
    '{3'd2, 16'h4000, 14'sd1000, -14'sd600, -14'sd600,  -14'sd1000},
    '{3'd3, 16'h4000, 14'sd1000, -14'sd600,  14'sd600,  -14'sd1000},
    '{3'd4, 16'h4000, 14'sd1000, -14'sd600, -14'sd600,   14'sd1000},
    '{3'd1, 16'h8000, 14'sd1000, -14'sd600, -14'sd1000,  14'sd600},
    '{3'd1, 16'hC000, 14'sd1000, -14'sd600, -14'sd600,  -14'sd1000},
    '{3'd2, 16'hC000, 14'sd1000, -14'sd600,  14'sd600,   14'sd1000},
    '{3'd3, 16'hC000, 14'sd1000, -14'sd600, -14'sd600,   14'sd1000},
    '{3'd4, 16'hC000, 14'sd1000, -14'sd600,  14'sd600,  -14'sd1000},
    '{3'd0, 16'h4000, 14'sd1234, -14'sd4321, 14'sd1234, -14'sd4321},
    '{3'd5, 16'h4000, 14'sd1234, -14'sd4321, 14'sd1234, -14'sd4321},
    '{3'd7, 16'hC000, 14'sd1234, -14'sd4321, 14'sd1234, -14'sd4321}
  };

  localparam int ROT_A [4] = '{1000, 0, -1000, 0};
  localparam int ROT_B [4] = '{0, 1000, 0, -1000};

  function automatic string req_of(logic [2:0] m);
    case (m)
      3'd1:    return "R6";
      3'd2:    return "R7";
      3'd3:    return "R8";
      3'd4:    return "R9";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string req, logic signed [13:0] act, logic signed [13:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_ne(string req, logic signed [13:0] act, logic signed [13:0] bad);
    total++;
    if (act === bad) begin
      fails++;
      $display("FAIL %s: actual %0d expected a value other than %0d", req, act, bad);
    end
  endtask

  task automatic drive(logic en, logic lp, logic [2:0] m, logic [31:0] fw,
                       logic [15:0] ofs, logic signed [13:0] vi, logic signed [13:0] vq);
    @(negedge clk);
    nco_en = en; lp_mode = lp; mod_sel = m; freq_word = fw;
    phase_ofs = ofs; in_i = vi; in_q = vq;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    total = 0; fails = 0;
    rst_n = 1'b0; nco_en = 1'b1; lp_mode = 1'b0; mod_sel = 3'd0;
    freq_word = 32'd0; phase_ofs = 16'd0; in_i = 14'sd500; in_q = -14'sd77;

    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_a", out_a, 14'sd0);
    chk("R1 out_b", out_b, 14'sd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Vector table: modes R5..R9 at fixed phases
    for (int k = 0; k < 13; k++) begin
      drive(1'b1, 1'b0, VEC[k].mode, 32'd0, VEC[k].ofs, VEC[k].vi, VEC[k].vq);
      settle();
      chk({req_of(VEC[k].mode), " out_a"}, out_a, VEC[k].ea);
      chk({req_of(VEC[k].mode), " out_b"}, out_b, VEC[k].eb);
    end

    // R2 latency: two edges
    drive(1'b1, 1'b0, 3'd0, 32'd0, 16'd0, 14'sd111, 14'sd0);
    settle();
    drive(1'b1, 1'b0, 3'd0, 32'd0, 16'd0, 14'sd222, 14'sd0);
    @(posedge clk); @(negedge clk);
    chk("R2 after one edge", out_a, 14'sd111);
    @(posedge clk); @(negedge clk);
    chk("R2 after two edges", out_a, 14'sd222);

    // R11 round-half-up
    drive(1'b1, 1'b0, 3'd1, 32'd0, 16'h0000, 14'sd4096, 14'sd0);
    settle();
    chk("R11 positive half", out_a, 14'sd4096);
    chk("R11 zero term", out_b, 14'sd0);
    drive(1'b1, 1'b0, 3'd1, 32'd0, 16'h0000, -14'sd4096, 14'sd0);
    settle();
    chk("R11 negative half", out_a, -14'sd4095);

    // R12 clipping at 45 degrees
    drive(1'b1, 1'b0, 3'd1, 32'd0, 16'h2000, 14'sd8191, -14'sd8192);
    settle();
    chk("R12 high clip", out_a, 14'sd8191);
    drive(1'b1, 1'b0, 3'd2, 32'd0, 16'h2000, -14'sd8192, -14'sd8192);
    settle();
    chk("R12 low clip", out_a, -14'sd8192);

    // R3 quarter-turn rotation from a cleared accumulator
    drive(1'b0, 1'b0, 3'd1, 32'h4000_0000, 16'h0000, 14'sd1000, 14'sd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    nco_en = 1'b1;
    for (int n = 1; n <= 9; n++) begin
      @(posedge clk); @(negedge clk);
      if (n >= 2) begin
        chk("R3 rotation a", out_a, 14'(ROT_A[(n-2)%4]));
        chk("R3 rotation b", out_b, 14'(ROT_B[(n-2)%4]));
      end
    end

    // R4 clear wins over the step in the same cycle
    nco_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 cleared a", out_a, 14'sd1000);
    chk("R4 cleared b", out_b, 14'sd0);
    @(posedge clk); @(negedge clk);
    chk("R4 held a", out_a, 14'sd1000);
    drive(1'b0, 1'b0, 3'd1, 32'h4000_0000, 16'h4000, 14'sd1000, 14'sd0);
    settle();
    chk("R4 offset while held", out_b, 14'sd1000);

    // R10 offset masking
    drive(1'b1, 1'b1, 3'd1, 32'd0, 16'h47FF, 14'sd1000, -14'sd600);
    settle();
    chk("R10 low-power offset a", out_a, 14'sd600);
    chk("R10 low-power offset b", out_b, 14'sd1000);
    drive(1'b1, 1'b0, 3'd1, 32'd0, 16'h47FF, 14'sd1000, -14'sd600);
    settle();
    chk_ne("R10 full-resolution offset", out_a, 14'sd600);

    // R10 tuning-word masking over a long rotation
    drive(1'b0, 1'b1, 3'd1, 32'h47FF_FFFF, 16'h0000, 14'sd1000, 14'sd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    nco_en = 1'b1;
    for (int n = 1; n <= 17; n++) begin
      @(posedge clk); @(negedge clk);
      if (n >= 2) begin
        chk("R10 low-power rotation a", out_a, 14'(ROT_A[(n-2)%4]));
        chk("R10 low-power rotation b", out_b, 14'(ROT_B[(n-2)%4]));
      end
    end

    finish_run();
  end

endmodule